// File: doc/BRIEF.md
# Maskable Interrupt Gate with Fast Routing and Wake

This block gathers 32 level-sensitive interrupt requests into three request lines. Every request passes an enable bit of its own. A second per-source bit then sends it either to the normal request line or to the fast request line. Sources 0 to 7 are individual GPIO pins. Source 8 is the merged request from the upper GPIO bank. A real-time-clock alarm sits at a parameter-chosen index, 20 by default. The remaining sources are internal peripherals that hold their request until they are serviced. No acknowledge is needed at this level.

Wake-up uses a separate path. A wake-enable register marks which sources may raise a wake request while the low-power input is high, and the per-source enable bits play no part in it. Only the nine GPIO-related sources and the alarm have a wake-enable bit. Every other wake-enable position is tied to zero. Software reaches the enable, route, wake-enable and pending registers through a plain word port with a combinational read. All three request outputs leave the block through one register stage.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset the enable, route and wake-enable registers read 0, and irq_o, fiq_o and wake_o stay low even when every source and lp_mode_i are high.
- R2: irq_o is high one cycle after any source is high whose enable bit is 1 and whose route bit is 0.
- R3: fiq_o is high one cycle after any source is high whose enable bit is 1 and whose route bit is 1. A route bit of 1 keeps that source off irq_o.
- R4: A read at offset 0x0 returns the source vector ANDed with the enable register. Writes to offset 0x0 change no register.
- R5: The enable register is written and read at offset 0x4. An enable bit of 0 keeps that source off both irq_o and fiq_o.
- R6: The route register is written and read at offset 0x8. Bit n = 1 selects the fast line for source n.
- R7: The wake-enable register sits at offset 0xC. Only bits 0 to 8 and the alarm bit (20) store a value, and all other bits read 0. With the default parameters, writing all ones reads back 0x001001FF.
- R8: wake_o is high one cycle after lp_mode_i is high while any wake-enabled source is high, whatever the enable bits hold. wake_o is low one cycle after lp_mode_i is low.
- R9: Requests are levels. An output stays high while its qualifying source stays high, and it falls one cycle after the source drops or its enable bit is cleared.
- R10: Reads at any other offset return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt sources |
| lp_mode_i | input | 1 | Low-power state indication, qualifies wake |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |
| wake_o | output | 1 | Wake-up request, registered |

## Verification
Two collisions are provoked. In the first, a write to the enable register and the rise of the matching source are driven in the same cycle. The bench then expects irq_o to stay low for one cycle, because the output register samples the old enable, and to go high in the cycle after. In the second, the alarm source is active while its enable bit is 0, its wake-enable bit is 1 and lp_mode_i is high. The bench judges that wake_o rises while irq_o and fiq_o stay low, which shows the wake path does not depend on the enable bits.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  localparam int unsigned IRQG_OFF_PEND  = 32'h0;
  localparam int unsigned IRQG_OFF_MASK  = 32'h4;
  localparam int unsigned IRQG_OFF_ROUTE = 32'h8;
  localparam int unsigned IRQG_OFF_WAKE  = 32'hC;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_PEND,
    RS_MASK,
    RS_ROUTE,
    RS_WAKE
  } irqg_sel_e;

  // Map a byte offset to the register it selects.
  function automatic irqg_sel_e irqg_decode(input logic [7:0] off);
    irqg_sel_e s;
    case (off)
      8'(IRQG_OFF_PEND):  s = RS_PEND;
      8'(IRQG_OFF_MASK):  s = RS_MASK;
      8'(IRQG_OFF_ROUTE): s = RS_ROUTE;
      8'(IRQG_OFF_WAKE):  s = RS_WAKE;
      default:            s = RS_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irqg_regs.sv
module irqg_regs
  import irqg_pkg::*;
#(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned WAKE_LO   = 9,
  parameter int unsigned ALARM_SRC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  irqg_sel_e       sel,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] wake_q
);

  function automatic logic [NSRC-1:0] wake_capable();
    logic [NSRC-1:0] v;
    for (int i = 0; i < int'(NSRC); i++)
      v[i] = (i < int'(WAKE_LO)) || (i == int'(ALARM_SRC));
    return v;
  endfunction

  localparam logic [NSRC-1:0] WAKE_OK = wake_capable();

  logic wr_mask, wr_route, wr_wake, wr_pend;
  assign wr_mask  = reg_we && (sel == RS_MASK);
  assign wr_route = reg_we && (sel == RS_ROUTE);
  assign wr_wake  = reg_we && (sel == RS_WAKE);
  assign wr_pend  = reg_we && (sel == RS_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= reg_wdata;
      if (wr_route) route_q <= reg_wdata;
    end
  end

  for (genvar g = 0; g < int'(NSRC); g++) begin : g_wake
    if (WAKE_OK[g]) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n)       wake_q[g] <= 1'b0;
        else if (wr_wake) wake_q[g] <= reg_wdata[g];
      end
    end else begin : g_tie
      assign wake_q[g] = 1'b0;
    end
  end

  assert_ro_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ($stable(mask_q) && $stable(route_q) && $stable(wake_q)));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata)));

  assert_route_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_route |=> $stable(route_q));

  assert_wake_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wake |=> (wake_q == ($past(reg_wdata) & WAKE_OK)));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == RS_NONE) |=> ($stable(mask_q) && $stable(route_q) && $stable(wake_q)));

endmodule

// File: rtl/irqg_reduce.sv
module irqg_reduce #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  input  logic            qual,
  output logic            hit,
  output logic            req_q
);

  function automatic logic any_active(input logic [NSRC-1:0] s,
                                      input logic [NSRC-1:0] e);
    return |(s & e);
  endfunction

  assign hit = qual && any_active(src, en);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= hit;
  end

  assert_req_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> req_q);

  assert_req_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !req_q);

endmodule

// File: rtl/irqg_rdmux.sv
module irqg_rdmux
  import irqg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  irqg_sel_e       sel,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] route_q,
  input  logic [NSRC-1:0] wake_q,
  output logic [NSRC-1:0] rdata
);

  always_comb begin
    case (sel)
      RS_PEND:  rdata = src & mask_q;
      RS_MASK:  rdata = mask_q;
      RS_ROUTE: rdata = route_q;
      RS_WAKE:  rdata = wake_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irqg_pkg::*;
#(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned WAKE_LO   = 9,
  parameter int unsigned ALARM_SRC = 20,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              lp_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);

  irqg_sel_e       sel;
  logic [NSRC-1:0] mask_q, route_q, wake_q;
  logic [NSRC-1:0] en_normal, en_fast;
  logic            normal_hit, fast_hit, wake_hit;

  assign sel       = irqg_decode(8'(reg_addr_i));
  assign en_normal = mask_q & ~route_q;
  assign en_fast   = mask_q &  route_q;

  irqg_regs #(.NSRC(NSRC), .WAKE_LO(WAKE_LO), .ALARM_SRC(ALARM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we_i), .sel(sel),
    .reg_wdata(reg_wdata_i), .mask_q(mask_q), .route_q(route_q), .wake_q(wake_q)
  );

  irqg_reduce #(.NSRC(NSRC)) u_normal (
    .clk(clk), .rst_n(rst_n), .src(src_i), .en(en_normal), .qual(1'b1),
    .hit(normal_hit), .req_q(irq_o)
  );

  irqg_reduce #(.NSRC(NSRC)) u_fast (
    .clk(clk), .rst_n(rst_n), .src(src_i), .en(en_fast), .qual(1'b1),
    .hit(fast_hit), .req_q(fiq_o)
  );

  irqg_reduce #(.NSRC(NSRC)) u_wake (
    .clk(clk), .rst_n(rst_n), .src(src_i), .en(wake_q), .qual(lp_mode_i),
    .hit(wake_hit), .req_q(wake_o)
  );

  irqg_rdmux #(.NSRC(NSRC)) u_rdmux (
    .sel(sel), .src(src_i), .mask_q(mask_q), .route_q(route_q),
    .wake_q(wake_q), .rdata(reg_rdata_o)
  );

  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_o);

  assert_fiq_unrouted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> !fiq_o);

  assert_lines_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(src_i & mask_q) == 1) |=> $onehot0({irq_o, fiq_o}));

  assert_wake_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode_i |=> !wake_o);

  assert_wake_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_i && ((src_i & wake_q) != '0)) |=> wake_o);

endmodule

// File: tb/irq_gate_ctrl_bench.sv
module irq_gate_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        lp = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] WAKE_CAP = 32'h0010_01FF;

  always #4 clk = ~clk;

  irq_gate_ctrl u_irq_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .lp_mode_i(lp),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Apply a new source vector and wait until the output register has taken it.
  task automatic drive(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    src = '1; lp = 1'b1;
    @(negedge clk);
    check("R1 irq in reset", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    drive('1);
    rd(4'h4, v); check("R1 mask after reset", v, 32'h0);
    rd(4'h8, v); check("R1 route after reset", v, 32'h0);
    rd(4'hC, v); check("R1 wake after reset", v, 32'h0);
    check("R1 outputs idle", {29'b0, irq, fiq, wake}, 32'h0);
    src = '0; lp = 1'b0;
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(4'h4, 32'hA5A5_0F0F);
    rd(4'h4, v); check("R5 mask readback", v, 32'hA5A5_0F0F);
    wr(4'h8, 32'h3C3C_1234);
    rd(4'h8, v); check("R6 route readback", v, 32'h3C3C_1234);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R4 pending write left mask", v, 32'hA5A5_0F0F);
    rd(4'h8, v); check("R4 pending write left route", v, 32'h3C3C_1234);
    wr(4'h2, 32'h1234_5678);
    rd(4'h4, v); check("R10 unmapped write left mask", v, 32'hA5A5_0F0F);
    rd(4'h2, v); check("R10 unmapped read zero", v, 32'h0);
  endtask

  task automatic t_normal_fast;
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0);
    drive(32'h0002_0000);
    check("R2 normal request", {30'b0, irq, fiq}, 32'h2);
    wr(4'h8, 32'h0002_0000);
    drive(32'h0002_0000);
    check("R3 fast request only", {30'b0, irq, fiq}, 32'h1);
    drive(32'h0002_0004);
    check("R3 both lines", {30'b0, irq, fiq}, 32'h3);
    wr(4'h4, 32'hFFFD_FFFB);
    drive(32'h0002_0004);
    check("R5 masked sources blocked", {30'b0, irq, fiq}, 32'h0);
    drive(32'h0);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    wr(4'h4, 32'h0000_FF00);
    src = 32'h0F0F_0F0F;
    rd(4'h0, v); check("R4 pending value", v, 32'h0000_0F00);
    src = 32'h0;
    rd(4'h0, v); check("R4 pending follows source", v, 32'h0);
  endtask

  task automatic t_level;
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h0000_0100);
    drive(32'h0000_0100);
    check("R9 asserted", {31'b0, irq}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R9 held while level", {31'b0, irq}, 32'h1);
    drive(32'h0);
    check("R9 drops with source", {31'b0, irq}, 32'h0);
    drive(32'h0000_0100);
    wr(4'h4, 32'h0);
    check("R9 still high one cycle after mask write", {31'b0, irq}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R9 drops with mask", {31'b0, irq}, 32'h0);
    drive(32'h0);
  endtask

  task automatic t_wake;
    logic [31:0] v;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); check("R7 wake capable bits", v, WAKE_CAP);
    wr(4'h4, 32'h0);
    lp = 1'b1;
    drive(32'h0010_0000);
    check("R8 alarm wakes with mask off", {29'b0, irq, fiq, wake}, 32'h1);
    drive(32'h0000_1000);
    check("R7 non-capable source no wake", {31'b0, wake}, 32'h0);
    drive(32'h0000_0008);
    check("R8 gpio wakes", {31'b0, wake}, 32'h1);
    lp = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 no wake out of low power", {31'b0, wake}, 32'h0);
    wr(4'hC, 32'h0);
    lp = 1'b1;
    drive(32'h0010_01FF);
    check("R8 wake-enable clear blocks", {31'b0, wake}, 32'h0);
    lp = 1'b0;
    drive(32'h0);
  endtask

  task automatic t_same_cycle;
    wr(4'h4, 32'h0);
    @(negedge clk);
    we = 1'b1; addr = 4'h4; wdata = 32'h0000_0008; src = 32'h0000_0008;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    check("R2 old mask seen in collision cycle", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R2 request after collision", {31'b0, irq}, 32'h1);
    drive(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_normal_fast();
    t_pending();
    t_level();
    t_wake();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule